// File: doc/BRIEF.md
# ADC Start Controller

This block decides when an analog-to-digital converter begins a conversion. A start can come from a software write or from one of four hardware event lines: a compare event from a capture/compare unit, an event from a charge-time measurement unit, a timer event and a real-time clock event. Each hardware line counts only when its own qualifier is true. A global module enable gates every start.

An accepted start raises the busy/complete flag `go_done`. The block then waits out a programmable acquisition window, measured in ticks of `tick`. After that it issues a one-cycle `conv_start` to the converter and waits for the converter's `conv_done`. A compare event whose unit is in trigger mode always clears the associated timer, even when the module is disabled, so that acquisitions repeat on their own.

The controller is a five-state machine:
- **IDLE** goes to **ACQ** on an accepted start when the acquisition field is nonzero.
- **IDLE** goes to **DEFER** on an accepted start when the acquisition field is zero.
- **ACQ** goes to **START** when the acquisition counter expires on a tick.
- **DEFER** goes to **START** on the next tick.
- **START** goes to **CONV** after one cycle.
- **CONV** goes to **IDLE** when `conv_done` is seen. This is the completion transition.
- Any busy state goes to **IDLE** when `mod_en` falls. This is the abort transition.

Top module: `adc_start_ctrl`

## Requirements
- R1: A compare event (`cmp_ev`) is a start request only while `cmp_mode` equals 4'b1011; any other mode value leaves `go_done` at 0.
- R2: A charge-time event (`ctm_ev`) is a start request only while `ctm_trig_en` is 1.
- R3: A timer event (`tmr_ev`) and a real-time clock event (`rtc_ev`) are each a start request with no further qualifier.
- R4: An accepted request in IDLE sets `go_done` to 1 from the following cycle; `conv_start` is only ever high while `go_done` is 1.
- R5: While `mod_en` is 0, every request (hardware or software) is ignored and `go_done` stays 0.
- R6: `cmp_tmr_clr` is high in the same cycle as a compare event with `cmp_mode` equal to 4'b1011, regardless of `mod_en`, and low otherwise.
- R7: With `acq_sel` = N > 0, `conv_start` rises in the cycle after the 2N-th tick counted after the accepting edge.
- R8: With `acq_sel` = 0, `conv_start` rises in the cycle after the first tick following the accepting edge.
- R9: `conv_start` is high for exactly one cycle per conversion.
- R10: After `conv_done` is seen during conversion, `go_done` is 0 and `done_irq` is 1 in the next cycle; `done_irq` lasts one cycle.
- R11: Requests arriving while `go_done` is 1 are dropped, and several requests in one cycle start exactly one conversion.
- R12: A one-cycle `sw_go` pulse starts a conversion under the same enable rule as hardware requests.
- R13: Clearing `mod_en` while busy returns the block to idle with `go_done` 0, no `done_irq` and no further `conv_start`.
- R14: After reset, `go_done`, `conv_start` and `done_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_en | input | 1 | Module enable; 0 blocks starts and aborts a running operation |
| acq_sel | input | 3 | Acquisition setting N; window is 2N ticks, 0 means one-tick deferral |
| sw_go | input | 1 | Software start pulse (write of 1 to the flag) |
| cmp_ev | input | 1 | Compare event from the capture/compare unit |
| cmp_mode | input | 4 | Mode field of the capture/compare unit |
| ctm_ev | input | 1 | Event from the charge-time measurement unit |
| ctm_trig_en | input | 1 | Trigger enable of the charge-time measurement unit |
| tmr_ev | input | 1 | Timer event |
| rtc_ev | input | 1 | Real-time clock event |
| tick | input | 1 | Acquisition / instruction-cycle tick strobe |
| conv_done | input | 1 | Converter reports end of conversion |
| go_done | output | 1 | Busy flag: 1 from acceptance until completion or abort |
| conv_start | output | 1 | One-cycle request to the converter to begin |
| done_irq | output | 1 | One-cycle completion pulse |
| cmp_tmr_clr | output | 1 | Clear to the timer paired with the compare unit |

## Verification
The bench aims at the following corner cases:
- **Acquisition length.** It counts ticks exactly at both ends of the acquisition range and at the zero setting. A counter that is off by one or loads N instead of 2N gives the wrong tick count.
- **Timer clear while disabled.** A compare event arrives while the module is disabled. A design that gates the timer clear with the enable loses the automatic repeat, and a design that lets the start through raises the flag.
- **Busy and simultaneous requests.** Requests are sent while busy and all at once. A design that does not drop them would restart or emit a second `conv_start`.
- **Abort.** The module is disabled mid-acquisition. A design that treats the abort as a completion would raise `done_irq` or later start the converter.

// File: rtl/adc_start_pkg.sv
package adc_start_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQ,
        ST_DEFER,
        ST_START,
        ST_CONV
    } adc_state_e;

    localparam int          NUM_SRC      = 4;
    localparam logic [3:0]  CMP_TRIG_MODE = 4'b1011;
    localparam int          SRC_CMP = 0;
    localparam int          SRC_CTM = 1;
    localparam int          SRC_TMR = 2;
    localparam int          SRC_RTC = 3;
endpackage

// File: rtl/adc_trig_qual.sv
module adc_trig_qual #(
    parameter int NSRC = 4
) (
    input  logic [NSRC-1:0] src_ev,
    input  logic [NSRC-1:0] src_qual,
    input  logic            sw_go,
    input  logic            mod_en,
    input  logic            idle,
    output logic [NSRC-1:0] src_hit,
    output logic            accept
);
    // Per-source qualification, one gate per source
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign src_hit[i] = src_ev[i] & src_qual[i];
    end

    // Any qualified request while enabled and idle starts one conversion
    assign accept = mod_en & idle & ((|src_hit) | sw_go);
endmodule

// File: rtl/adc_acq_timer.sv
module adc_acq_timer #(
    parameter int ACQ_W = 3,
    parameter int MULT  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ACQ_W-1:0] acq_sel,
    input  logic             run,
    input  logic             tick,
    output logic             expire
);
    localparam int CNT_W = ACQ_W + $clog2(MULT) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    assign load_val = CNT_W'(acq_sel) * CNT_W'(MULT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = run & tick & (cnt_q == CNT_W'(1));
endmodule

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl
    import adc_start_pkg::*;
#(
    parameter int ACQ_W    = 3,
    parameter int ACQ_MULT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_en,
    input  logic [ACQ_W-1:0] acq_sel,
    input  logic             sw_go,
    input  logic             cmp_ev,
    input  logic [3:0]       cmp_mode,
    input  logic             ctm_ev,
    input  logic             ctm_trig_en,
    input  logic             tmr_ev,
    input  logic             rtc_ev,
    input  logic             tick,
    input  logic             conv_done,
    output logic             go_done,
    output logic             conv_start,
    output logic             done_irq,
    output logic             cmp_tmr_clr
);
    adc_state_e state_q, state_d;

    logic [NUM_SRC-1:0] src_ev, src_qual, src_hit;
    logic               accept;
    logic               acq_expire;
    logic               acq_load;
    logic               done_irq_q;

    // Source vector assembly
    assign src_ev[SRC_CMP]   = cmp_ev;
    assign src_ev[SRC_CTM]   = ctm_ev;
    assign src_ev[SRC_TMR]   = tmr_ev;
    assign src_ev[SRC_RTC]   = rtc_ev;
    assign src_qual[SRC_CMP] = (cmp_mode == CMP_TRIG_MODE);
    assign src_qual[SRC_CTM] = ctm_trig_en;
    assign src_qual[SRC_TMR] = 1'b1;
    assign src_qual[SRC_RTC] = 1'b1;

    adc_trig_qual #(
        .NSRC (NUM_SRC)
    ) u_qual (
        .src_ev   (src_ev),
        .src_qual (src_qual),
        .sw_go    (sw_go),
        .mod_en   (mod_en),
        .idle     (state_q == ST_IDLE),
        .src_hit  (src_hit),
        .accept   (accept)
    );

    assign acq_load = accept && (acq_sel != '0);

    adc_acq_timer #(
        .ACQ_W (ACQ_W),
        .MULT  (ACQ_MULT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (acq_load),
        .acq_sel (acq_sel),
        .run     (state_q == ST_ACQ),
        .tick    (tick),
        .expire  (acq_expire)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = (acq_sel == '0) ? ST_DEFER : ST_ACQ;
            end
            ST_ACQ: begin
                if (!mod_en)         state_d = ST_IDLE;
                else if (acq_expire) state_d = ST_START;
            end
            ST_DEFER: begin
                if (!mod_en)   state_d = ST_IDLE;
                else if (tick) state_d = ST_START;
            end
            ST_START: begin
                if (!mod_en) state_d = ST_IDLE;
                else         state_d = ST_CONV;
            end
            ST_CONV: begin
                if (!mod_en || conv_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_irq_q <= 1'b0;
        else        done_irq_q <= (state_q == ST_CONV) && mod_en && conv_done;
    end

    always_comb begin
        go_done     = (state_q != ST_IDLE);
        conv_start  = (state_q == ST_START);
        done_irq    = done_irq_q;
        cmp_tmr_clr = src_hit[SRC_CMP];
    end
endmodule

// File: rtl/adc_start_ctrl_chk.sv
module adc_start_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic mod_en,
    input logic go_done,
    input logic conv_start,
    input logic done_irq
);
    assert_disabled_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> !go_done);

    assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> go_done);

    assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_irq_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> (!go_done && $past(go_done)));

    assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    assert_rise_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go_done) |-> $past(mod_en));

    assert_abort_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (go_done && !mod_en) |=> !done_irq);
endmodule

bind adc_start_ctrl adc_start_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mod_en     (mod_en),
    .go_done    (go_done),
    .conv_start (conv_start),
    .done_irq   (done_irq)
);

// File: tb/sim_adc_start_ctrl.sv
`timescale 1ns/1ps
module sim_adc_start_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mod_en = 1'b0;
    logic [2:0] acq_sel = 3'd0;
    logic       sw_go = 1'b0, cmp_ev = 1'b0, ctm_ev = 1'b0, ctm_trig_en = 1'b0;
    logic       tmr_ev = 1'b0, rtc_ev = 1'b0, tick = 1'b0, conv_done = 1'b0;
    logic [3:0] cmp_mode = 4'd0;
    logic       go_done, conv_start, done_irq, cmp_tmr_clr;

    int total = 0, bad = 0, cycles = 0, tc = 0;
    logic tick_prev;

    always #5 clk = ~clk;

    adc_start_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .acq_sel(acq_sel),
        .sw_go(sw_go), .cmp_ev(cmp_ev), .cmp_mode(cmp_mode), .ctm_ev(ctm_ev),
        .ctm_trig_en(ctm_trig_en), .tmr_ev(tmr_ev), .rtc_ev(rtc_ev),
        .tick(tick), .conv_done(conv_done), .go_done(go_done),
        .conv_start(conv_start), .done_irq(done_irq), .cmp_tmr_clr(cmp_tmr_clr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: remember the tick seen at the edge, then update stimulus tick
    task automatic cyc();
        tick_prev = tick;
        @(posedge clk);
        #2;
        cycles++;
        tc++;
        tick = (tc % 3 == 0);
    endtask

    task automatic clear_ev();
        sw_go = 0; cmp_ev = 0; ctm_ev = 0; tmr_ev = 0; rtc_ev = 0;
    endtask

    // After the accepting edge: count ticks until conv_start, then finish handshake
    task automatic run_to_done(input int exp_ticks, input string req);
        int n = 0;
        int guard = 0;
        while (guard < 200) begin
            cyc();
            guard++;
            if (tick_prev) n++;
            if (conv_start) break;
        end
        chk(conv_start == 1'b1 && n == exp_ticks, req, n, exp_ticks);
        cyc();
        chk(conv_start == 1'b0 && go_done == 1'b1, "R9", conv_start, 0);
        conv_done = 1;
        cyc();
        conv_done = 0;
        chk(go_done == 1'b0 && done_irq == 1'b1, "R10", {go_done, done_irq}, 1);
        cyc();
        chk(done_irq == 1'b0, "R10", done_irq, 0);
    endtask

    task automatic t_reset();
        chk(go_done == 0 && conv_start == 0 && done_irq == 0, "R14",
            {go_done, conv_start, done_irq}, 0);
    endtask

    task automatic t_cmp();
        mod_en = 1; acq_sel = 3'd1;
        cmp_mode = 4'b1010; cmp_ev = 1; #1;
        chk(cmp_tmr_clr == 0, "R6", cmp_tmr_clr, 0);
        cyc(); cmp_ev = 0;
        chk(go_done == 0, "R1", go_done, 0);
        cmp_mode = 4'b1011; cmp_ev = 1; #1;
        chk(cmp_tmr_clr == 1, "R6", cmp_tmr_clr, 1);
        cyc(); cmp_ev = 0;
        chk(go_done == 1, "R1", go_done, 1);
        run_to_done(2, "R7");
    endtask

    task automatic t_ctm();
        acq_sel = 3'd7;
        ctm_trig_en = 0; ctm_ev = 1; cyc(); ctm_ev = 0;
        chk(go_done == 0, "R2", go_done, 0);
        ctm_trig_en = 1; ctm_ev = 1; cyc(); ctm_ev = 0;
        chk(go_done == 1, "R2", go_done, 1);
        run_to_done(14, "R7");
    endtask

    task automatic t_tmr_rtc();
        acq_sel = 3'd0;
        tmr_ev = 1; cyc(); tmr_ev = 0;
        chk(go_done == 1, "R3", go_done, 1);
        run_to_done(1, "R8");
        acq_sel = 3'd3;
        rtc_ev = 1; cyc(); rtc_ev = 0;
        chk(go_done == 1, "R3", go_done, 1);
        run_to_done(6, "R7");
    endtask

    task automatic t_disabled();
        mod_en = 0; cmp_mode = 4'b1011;
        cmp_ev = 1; tmr_ev = 1; sw_go = 1; #1;
        chk(cmp_tmr_clr == 1, "R6", cmp_tmr_clr, 1);
        cyc(); clear_ev();
        chk(go_done == 0, "R5", go_done, 0);
        cyc();
        chk(go_done == 0 && conv_start == 0, "R5", go_done, 0);
        mod_en = 1;
    endtask

    task automatic t_sw();
        acq_sel = 3'd2;
        sw_go = 1; cyc(); sw_go = 0;
        chk(go_done == 1, "R12", go_done, 1);
        run_to_done(4, "R12");
    endtask

    task automatic t_busy_multi();
        int starts = 0;
        acq_sel = 3'd2;
        cmp_ev = 1; ctm_ev = 1; tmr_ev = 1; rtc_ev = 1; sw_go = 1;
        cyc(); clear_ev();
        chk(go_done == 1, "R4", go_done, 1);
        for (int i = 0; i < 40; i++) begin
            if (i == 2) tmr_ev = 1;
            if (i == 3) tmr_ev = 0;
            if (go_done && conv_start == 0 && starts == 1 && i > 20) conv_done = 1;
            cyc();
            conv_done = 0;
            if (conv_start) begin
                starts++;
                tmr_ev = 1;  // request during conversion: must be dropped
            end else begin
                tmr_ev = 0;
            end
        end
        chk(starts == 1, "R11", starts, 1);
        chk(go_done == 0, "R11", go_done, 0);
    endtask

    task automatic t_abort();
        int starts = 0;
        int irqs = 0;
        acq_sel = 3'd7;
        rtc_ev = 1; cyc(); rtc_ev = 0;
        cyc(); cyc();
        mod_en = 0; cyc();
        chk(go_done == 0 && done_irq == 0, "R13", {go_done, done_irq}, 0);
        mod_en = 1;
        for (int i = 0; i < 60; i++) begin
            cyc();
            if (conv_start) starts++;
            if (done_irq) irqs++;
        end
        chk(starts == 0 && irqs == 0 && go_done == 0, "R13", starts + irqs, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        rst_n = 1;
        cyc();
        t_reset();
        t_cmp();
        t_ctm();
        t_tmr_rtc();
        t_disabled();
        t_sw();
        t_busy_multi();
        t_abort();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule